// File: doc/BRIEF.md
# Shared Attribute Memory Arbiter

This block lets two unrelated agents share one small configuration store: a host port and a subsystem port. The store holds a 256-byte information area and a bank of eight configuration registers. Each port raises a level request together with a location, a direction and write data. It holds these until the block answers with a done level, then drops the request and waits for done to fall. Requests are asynchronous to the block. They are resynchronized on an arbitration tick, which a programmable clock-enable divider derives from the input clock.

When both ports reach the same location in the same tick and at least one of them writes, the block orders the accesses. A host write and a subsystem write to that location keep the host value and drop the subsystem value. Any other mix serves the host first and holds the subsystem in a wait state for one arbitration tick, so every read returns a whole old value or a whole new value.

Two handshake flags cross between the sides. `sub_irq` tells the subsystem that the host has written. `host_stschg_n` tells the host that the subsystem has written. Each flag is set by one side and cleared by the other, and both change only on the arbitration tick.

Each port has its own state machine with three states. `PS_IDLE` waits for a synchronized request. It goes to `PS_DONE` when the access is granted and performed, or to `PS_WAIT` when arbitration defers it. `PS_WAIT` goes to `PS_DONE` when its grant arrives, or back to `PS_IDLE` if the request vanishes. `PS_DONE` returns to `PS_IDLE` once the synchronized request is low. The host port is always granted.

Top module: `attr_mem_arbiter`

## Requirements
- R1: `div_sel` values 0, 1, 2 and 3 give an arbitration tick every N = 1, 2, 4 and 8 input clocks. A request raised between clock edges is answered by done after between 2N+1 and 3N rising edges.
- R2: Location bit 8 = 0 selects info byte [7:0], and bit 8 = 1 selects configuration register [2:0]. The host location is `host_addr[9:1]` and the subsystem location is `sub_addr[8:0]`. A byte written by one port reads back unchanged from the other port.
- R3: A host access with `host_addr[0]` = 1 still completes with done. It writes nothing, returns read data 0x00 and leaves both flags unchanged.
- R4: When host and subsystem write the same location in the same tick, both complete in that tick and the stored value is the host data.
- R5: A host write and a subsystem read of the same location in the same tick: the subsystem is held one tick (its done comes exactly N edges after the host's) and it reads the host's new value.
- R6: A host read and a subsystem write of the same location in the same tick: the host reads the old value, the subsystem is held one tick, and the subsystem value is then stored.
- R7: Same-tick accesses to different locations, or two reads, complete in the same tick and return the stored values.
- R8: `sub_irq` goes to 1 on every valid host write. A subsystem write of a byte with bit 6 = 1 to the control register (location 0x107) clears it. Bit 6 of the control register always reads back 0.
- R9: `host_stschg_n` goes low on a subsystem write performed while control register bit 2, as held before that write, is 1. It stays high when that bit is 0. A valid host read drives it high again.
- R10: If a flag's set and clear fall in the same tick, the flag ends set.
- R11: The done outputs and both flags change only on an arbitration tick. A host write raises `sub_irq` in the same tick that raises `host_done`.
- R12: After reset both done outputs are 0, `sub_irq` is 0, `host_stschg_n` is 1 and the control register reads 0x00.
- R13: Done stays high while the request is held, and falls between 2N+1 and 3N edges after the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the arbitration tick is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Arbitration divider select (N = 2^div_sel) |
| host_req | input | 1 | Host request level, asynchronous |
| host_we | input | 1 | Host direction, 1 = write |
| host_addr | input | 10 | Host byte address; bits 9..1 give the location, bit 0 must be 0 |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_done is high |
| host_done | output | 1 | Host access complete |
| sub_req | input | 1 | Subsystem request level, asynchronous |
| sub_we | input | 1 | Subsystem direction, 1 = write |
| sub_addr | input | 9 | Subsystem location |
| sub_wdata | input | 8 | Subsystem write data |
| sub_rdata | output | 8 | Subsystem read data, valid while sub_done is high |
| sub_done | output | 1 | Subsystem access complete |
| sub_irq | output | 1 | Active-high notice of host writes |
| host_stschg_n | output | 1 | Active-low notice of subsystem writes |

## Verification
The assertions rely on each port following the four-phase protocol. Address, direction and data stay stable from the rise of the request until done is seen, and a request is not raised again until done has fallen. The flag properties also rely on `div_sel` changing only while both ports are idle. The bench drives every access through tasks that wait for done before dropping the request and wait for done to fall before returning. It changes `div_sel` only between accesses, and it starts concurrent pairs on the same falling edge so that both requests reach the synchronizers in the same tick.

// File: rtl/attr_arb_pkg.sv
package attr_arb_pkg;
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_WAIT = 2'd1,
        PS_DONE = 2'd2
    } port_state_t;
endpackage

// File: rtl/arb_clk_div.sv
module arb_clk_div #(
    parameter int SEL_W = 2,
    localparam int CNT_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // terminal count is 2^sel - 1: one low bit set per select step
    always_comb begin
        lim = '0;
        for (int i = 0; i < CNT_W; i++) begin
            lim[i] = (i < int'(div_sel));
        end
    end

    assign tick = (cnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sh <= '0;
        else if (en) sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/arb_port_fsm.sv
module arb_port_fsm
    import attr_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req_s,
    input  logic grant,
    output logic fire,
    output logic done
);
    port_state_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PS_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (tick) begin
            unique case (st)
                PS_IDLE: if (req_s) st_nx = grant ? PS_DONE : PS_WAIT;
                PS_WAIT: begin
                    if (!req_s)     st_nx = PS_IDLE;
                    else if (grant) st_nx = PS_DONE;
                end
                PS_DONE: if (!req_s) st_nx = PS_IDLE;
                default: st_nx = PS_IDLE;
            endcase
        end
    end

    always_comb begin
        fire = tick && req_s && grant && (st == PS_IDLE || st == PS_WAIT);
        done = (st == PS_DONE);
    end
endmodule

// File: rtl/attr_mem_arbiter.sv
module attr_mem_arbiter
    import attr_arb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int INFO_BYTES  = 256,
    parameter int REG_COUNT   = 8,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int IRQ_CLR_BIT = 6,
    parameter int STS_EN_BIT  = 2,
    localparam int LOC_W = $clog2(INFO_BYTES) + 1,
    localparam int HA_W  = LOC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    input  logic              sub_req,
    input  logic              sub_we,
    input  logic [LOC_W-1:0]  sub_addr,
    input  logic [DATA_W-1:0] sub_wdata,
    output logic [DATA_W-1:0] sub_rdata,
    output logic              sub_done,
    output logic              sub_irq,
    output logic              host_stschg_n
);
    localparam int DEPTH    = INFO_BYTES + REG_COUNT;
    localparam int IDX_W    = $clog2(DEPTH);
    localparam int REG_AW   = $clog2(REG_COUNT);
    localparam int CTRL_IDX = DEPTH - 1;
    localparam logic [DATA_W-1:0] CLR_MASK = ~(DATA_W'(1) << IRQ_CLR_BIT);

    function automatic logic [IDX_W-1:0] loc_to_idx(input logic [LOC_W-1:0] loc);
        if (loc[LOC_W-1]) return IDX_W'(INFO_BYTES) + IDX_W'(loc[REG_AW-1:0]);
        else              return IDX_W'(loc[LOC_W-2:0]);
    endfunction

    logic arb_tick, h_req_s, s_req_s;
    logic h_fire, s_fire, s_grant;

    arb_clk_div #(.SEL_W(SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tick(arb_tick)
    );

    arb_sync #(.STAGES(SYNC_STAGES)) u_hsync (
        .clk(clk), .rst_n(rst_n), .en(arb_tick), .d(host_req), .q(h_req_s)
    );
    arb_sync #(.STAGES(SYNC_STAGES)) u_ssync (
        .clk(clk), .rst_n(rst_n), .en(arb_tick), .d(sub_req), .q(s_req_s)
    );

    arb_port_fsm u_hfsm (
        .clk(clk), .rst_n(rst_n), .tick(arb_tick), .req_s(h_req_s),
        .grant(1'b1), .fire(h_fire), .done(host_done)
    );
    arb_port_fsm u_sfsm (
        .clk(clk), .rst_n(rst_n), .tick(arb_tick), .req_s(s_req_s),
        .grant(s_grant), .fire(s_fire), .done(sub_done)
    );

    logic [IDX_W-1:0]  h_idx, s_idx;
    logic              h_valid, h_claim, s_discard;
    logic              h_wr, s_wr, h_rd, s_rd;
    logic [DATA_W-1:0] ctrl_q, h_rd_val, s_rd_val;
    logic              irq_q, sts_q;
    logic [DATA_W-1:0] mem [DEPTH];

    // conflict resolution: host always served first
    always_comb begin
        h_valid   = ~host_addr[0];
        h_idx     = loc_to_idx(host_addr[HA_W-1:1]);
        s_idx     = loc_to_idx(sub_addr);
        h_claim   = h_fire && h_valid && (h_idx == s_idx);
        s_grant   = !(h_claim && (host_we != sub_we));
        s_discard = h_claim && host_we && sub_we;
        h_wr      = h_fire && host_we && h_valid;
        s_wr      = s_fire && sub_we && !s_discard;
        h_rd      = h_fire && !host_we;
        s_rd      = s_fire && !sub_we;
        h_rd_val  = (h_idx == IDX_W'(CTRL_IDX)) ? ctrl_q : mem[h_idx];
        s_rd_val  = (s_idx == IDX_W'(CTRL_IDX)) ? ctrl_q : mem[s_idx];
    end

    always_ff @(posedge clk) begin
        if (s_wr && s_idx != IDX_W'(CTRL_IDX)) mem[s_idx] <= sub_wdata;
        if (h_wr && h_idx != IDX_W'(CTRL_IDX)) mem[h_idx] <= host_wdata;
    end

    logic irq_set, irq_clr, sts_set, sts_clr;
    always_comb begin
        irq_set = h_wr;
        irq_clr = s_wr && (s_idx == IDX_W'(CTRL_IDX)) && sub_wdata[IRQ_CLR_BIT];
        sts_set = s_wr && ctrl_q[STS_EN_BIT];
        sts_clr = h_rd && h_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            host_rdata <= '0;
            sub_rdata  <= '0;
            irq_q      <= 1'b0;
            sts_q      <= 1'b0;
        end else begin
            if (h_wr && h_idx == IDX_W'(CTRL_IDX))      ctrl_q <= host_wdata & CLR_MASK;
            else if (s_wr && s_idx == IDX_W'(CTRL_IDX)) ctrl_q <= sub_wdata & CLR_MASK;
            if (h_rd) host_rdata <= h_valid ? h_rd_val : '0;
            if (s_rd) sub_rdata  <= s_rd_val;
            if (arb_tick) begin
                irq_q <= irq_set | (irq_q & ~irq_clr);
                sts_q <= sts_set | (sts_q & ~sts_clr);
            end
        end
    end

    assign sub_irq       = irq_q;
    assign host_stschg_n = ~sts_q;
endmodule

// File: rtl/attr_arb_checker.sv
module attr_arb_checker #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arb_tick,
    input logic [SEL_W-1:0] div_sel,
    input logic             host_req,
    input logic             host_we,
    input logic             host_addr0,
    input logic             host_done,
    input logic             sub_req,
    input logic             sub_we,
    input logic             sub_done,
    input logic             sub_irq,
    input logic             host_stschg_n
);
    AST_FULL_RATE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == '0) |-> arb_tick); // R1

    AST_FLAGS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_tick |=> ($stable(sub_irq) && $stable(host_stschg_n))); // R11

    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_tick |=> ($stable(host_done) && $stable(sub_done))); // R11

    AST_HOST_WRITE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_done) && host_we && !host_addr0) |-> sub_irq); // R8

    AST_HOST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_done) && !host_we && !host_addr0 && !($rose(sub_done) && sub_we))
        |-> host_stschg_n); // R9

    AST_HOST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_done && host_req) |=> host_done); // R13

    AST_SUB_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_done && sub_req) |=> sub_done); // R13
endmodule

bind attr_mem_arbiter attr_arb_checker #(.SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .arb_tick(arb_tick), .div_sel(div_sel),
    .host_req(host_req), .host_we(host_we), .host_addr0(host_addr[0]),
    .host_done(host_done), .sub_req(sub_req), .sub_we(sub_we),
    .sub_done(sub_done), .sub_irq(sub_irq), .host_stschg_n(host_stschg_n)
);

// File: tb/attr_mem_arbiter_bench.sv
module attr_mem_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic       host_req = 1'b0, host_we = 1'b0;
    logic [9:0] host_addr = '0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       host_done;
    logic       sub_req = 1'b0, sub_we = 1'b0;
    logic [8:0] sub_addr = '0;
    logic [7:0] sub_wdata = '0, sub_rdata;
    logic       sub_done, sub_irq, host_stschg_n;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [264];

    always #5 clk = ~clk;

    attr_mem_arbiter u_attr_mem_arbiter (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_done(host_done),
        .sub_req(sub_req), .sub_we(sub_we), .sub_addr(sub_addr),
        .sub_wdata(sub_wdata), .sub_rdata(sub_rdata), .sub_done(sub_done),
        .sub_irq(sub_irq), .host_stschg_n(host_stschg_n)
    );

    function automatic int idx_of(input logic [8:0] loc);
        return loc[8] ? 256 + int'(loc[2:0]) : int'(loc[7:0]);
    endfunction

    function automatic logic [7:0] stored(input int idx, input logic [7:0] d);
        return (idx == 263) ? (d & 8'hBF) : d;
    endfunction

    function automatic int tick_n();
        return 1 << div_sel;
    endfunction

    function automatic logic [8:0] pool_loc(input int p);
        return (p < 6) ? 9'(p) : 9'(9'h100 + p - 6);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_op(input logic we, input logic [9:0] a, input logic [7:0] d,
                           output logic [7:0] q, output int lat, output logic irq_pre);
        @(negedge clk);
        host_we = we; host_addr = a; host_wdata = d; host_req = 1'b1;
        lat = 0; irq_pre = sub_irq;
        do begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (!host_done) irq_pre = sub_irq;
        end while (!host_done);
        q = host_rdata;
        host_req = 1'b0;
        while (host_done) @(negedge clk);
    endtask

    task automatic sub_op(input logic we, input logic [8:0] a, input logic [7:0] d,
                          output logic [7:0] q, output int lat);
        @(negedge clk);
        sub_we = we; sub_addr = a; sub_wdata = d; sub_req = 1'b1;
        lat = 0;
        do begin
            @(posedge clk); lat++;
            @(negedge clk);
        end while (!sub_done);
        q = sub_rdata;
        sub_req = 1'b0;
        while (sub_done) @(negedge clk);
    endtask

    task automatic sub_write(input logic [8:0] a, input logic [7:0] d);
        logic [7:0] q; int l;
        sub_op(1'b1, a, d, q, l);
        model[idx_of(a)] = stored(idx_of(a), d);
    endtask

    task automatic host_write(input logic [8:0] a, input logic [7:0] d);
        logic [7:0] q; int l; logic e;
        host_op(1'b1, {a, 1'b0}, d, q, l, e);
        model[idx_of(a)] = stored(idx_of(a), d);
    endtask

    // same-tick pair, expectations from the ordering rules
    task automatic pair(input logic hw, input logic [8:0] hl, input logic [7:0] hd,
                        input logic sw, input logic [8:0] sl, input logic [7:0] sd);
        int hi, si, h_lat, s_lat, exp_lat;
        logic [7:0] hq, sq, exp_h, exp_s, q2;
        logic e;
        bit same;
        string tag;
        hi = idx_of(hl); si = idx_of(sl); same = (hi == si);
        exp_h = model[hi]; exp_s = model[si];
        if (same && hw && !sw) exp_s = stored(hi, hd);
        if (same && hw && sw)       tag = "R4";
        else if (same && hw && !sw) tag = "R5";
        else if (same && !hw && sw) tag = "R6";
        else                        tag = "R7";
        fork
            host_op(hw, {hl, 1'b0}, hd, hq, h_lat, e);
            sub_op(sw, sl, sd, sq, s_lat);
        join
        if (!hw) check(hq == exp_h, tag, hq, exp_h);
        if (!sw) check(sq == exp_s, tag, sq, exp_s);
        exp_lat = (same && hw != sw) ? h_lat + tick_n() : h_lat;
        check(s_lat == exp_lat, tag, s_lat, exp_lat);
        if (sw && !(same && hw)) model[si] = stored(si, sd);
        if (hw) model[hi] = stored(hi, hd);
        if (same && (hw || sw)) begin
            host_op(1'b0, {hl, 1'b0}, 8'h00, q2, h_lat, e);
            check(q2 == model[hi], tag, q2, model[hi]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] q; int lat; logic e;
        void'($urandom(32'h1A2B3C4D));
        for (int i = 0; i < 264; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check(host_done == 1'b0, "R12", host_done, 0);
        check(sub_done == 1'b0, "R12", sub_done, 0);
        check(sub_irq == 1'b0, "R12", sub_irq, 0);
        check(host_stschg_n == 1'b1, "R12", host_stschg_n, 1);
        host_op(1'b0, 10'h20E, 8'h00, q, lat, e);
        check(q == 8'h00, "R12", q, 0);

        // R2: fill the pool and check cross-port readback
        for (int p = 0; p < 8; p++) sub_write(pool_loc(p), 8'($urandom));
        sub_write(9'h0FF, 8'h5A);
        host_op(1'b0, 10'h1FE, 8'h00, q, lat, e);
        check(q == 8'h5A, "R2", q, 8'h5A);
        host_write(9'h102, 8'h3C);
        sub_op(1'b0, 9'h102, 8'h00, q, lat);
        check(q == 8'h3C, "R2", q, 8'h3C);

        // R1: latency window per divider setting
        for (int s = 0; s < 4; s++) begin
            div_sel = 2'(s);
            host_op(1'b0, 10'h000, 8'h00, q, lat, e);
            check(lat >= 2 * tick_n() + 1 && lat <= 3 * tick_n(), "R1", lat, 3 * tick_n());
            check(q == model[0], "R1", q, model[0]);
        end

        // R13: done held while request held, then released in window
        div_sel = 2'd1;
        @(negedge clk);
        host_we = 1'b0; host_addr = 10'h002; host_req = 1'b1;
        while (!host_done) @(negedge clk);
        begin
            bit held = 1'b1;
            int rel = 0;
            repeat (6) begin @(negedge clk); if (!host_done) held = 1'b0; end
            check(held, "R13", held, 1);
            host_req = 1'b0;
            do begin @(posedge clk); rel++; @(negedge clk); end while (host_done);
            check(rel >= 5 && rel <= 6, "R13", rel, 6);
        end

        // R3: odd host address ignored
        div_sel = 2'd0;
        sub_write(9'h107, 8'h40);
        host_op(1'b1, 10'h001, 8'hAA, q, lat, e);
        check(sub_irq == 1'b0, "R3", sub_irq, 0);
        sub_op(1'b0, 9'h000, 8'h00, q, lat);
        check(q == model[0], "R3", q, model[0]);
        host_op(1'b0, 10'h001, 8'h00, q, lat, e);
        check(q == 8'h00, "R3", q, 0);

        // R8: irq set by host write, cleared by control write, bit 6 reads 0
        host_write(9'h002, 8'h77);
        check(sub_irq == 1'b1, "R8", sub_irq, 1);
        sub_write(9'h107, 8'h40);
        check(sub_irq == 1'b0, "R8", sub_irq, 0);
        host_op(1'b0, 10'h20E, 8'h00, q, lat, e);
        check(q == 8'h00, "R8", q, 0);

        // R9: status change gated by control bit 2
        sub_write(9'h003, 8'h11);
        check(host_stschg_n == 1'b1, "R9", host_stschg_n, 1);
        sub_write(9'h107, 8'h04);
        check(host_stschg_n == 1'b1, "R9", host_stschg_n, 1);
        sub_write(9'h003, 8'h22);
        check(host_stschg_n == 1'b0, "R9", host_stschg_n, 0);
        host_op(1'b0, 10'h006, 8'h00, q, lat, e);
        check(host_stschg_n == 1'b1, "R9", host_stschg_n, 1);
        check(q == 8'h22, "R9", q, 8'h22);

        // R10: set wins over a same-tick clear
        pair(1'b0, 9'h004, 8'h00, 1'b1, 9'h005, 8'h99);
        check(host_stschg_n == 1'b0, "R10", host_stschg_n, 0);
        pair(1'b1, 9'h004, 8'h5C, 1'b1, 9'h107, 8'h44);
        check(sub_irq == 1'b1, "R10", sub_irq, 1);
        sub_op(1'b0, 9'h107, 8'h00, q, lat);
        check(q == 8'h04, "R8", q, 8'h04);

        // R11: irq rises together with host done at divide-by-8
        div_sel = 2'd3;
        sub_write(9'h107, 8'h40);
        host_op(1'b1, 10'h002, 8'h31, q, lat, e);
        model[1] = 8'h31;
        check(e == 1'b0, "R11", e, 0);
        check(sub_irq == 1'b1, "R11", sub_irq, 1);

        // R4..R7 directed corners at divide-by-2
        div_sel = 2'd1;
        pair(1'b1, 9'h001, 8'hA1, 1'b1, 9'h001, 8'hB2);
        pair(1'b1, 9'h002, 8'hC3, 1'b0, 9'h002, 8'h00);
        pair(1'b0, 9'h003, 8'h00, 1'b1, 9'h003, 8'hD4);
        pair(1'b0, 9'h100, 8'h00, 1'b0, 9'h100, 8'h00);
        pair(1'b1, 9'h004, 8'hE5, 1'b1, 9'h101, 8'hF6);

        // constrained random mix over the pool
        for (int it = 0; it < 100; it++) begin
            int kind;
            logic [8:0] hl, sl;
            logic hw, sw;
            logic [7:0] hd, sd;
            div_sel = 2'((it / 25) % 4);
            kind = int'($urandom % 3);
            hl = pool_loc(int'($urandom % 8));
            sl = pool_loc(int'($urandom % 8));
            hw = 1'($urandom); sw = 1'($urandom);
            hd = 8'($urandom); sd = 8'($urandom);
            if (kind == 0) begin
                host_op(hw, {hl, 1'b0}, hd, q, lat, e);
                if (hw) model[idx_of(hl)] = hd;
                else    check(q == model[idx_of(hl)], "R2", q, model[idx_of(hl)]);
            end else if (kind == 1) begin
                sub_op(sw, sl, sd, q, lat);
                if (sw) model[idx_of(sl)] = sd;
                else    check(q == model[idx_of(sl)], "R2", q, model[idx_of(sl)]);
            end else begin
                pair(hw, hl, hd, sw, sl, sd);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule